// File: doc/BRIEF.md
# Serial Master Transmitter (clock idles high, sample on first edge)

This block is a serial master engine that sends words of a programmable length, 4 to 16 bits, most significant bit first. It runs in the mode where the serial clock rests high and the receiving side samples on the falling edge. A parent offers parallel words through a small queue interface: a valid flag, a data word and a pop strobe that the engine raises for one cycle when it takes a word. While a word goes out on the data line, the engine samples the incoming line on each falling clock edge and presents the received word, right-justified, with a one-cycle valid strobe.

A transfer starts by pulling the active-low frame select down. Half a serial period later the output driver turns on with the first bit. After another half period the clock makes its first falling edge. Outgoing bits change on rising edges. One full serial period after the last falling edge the frame select goes high again. When several words are queued they go out back to back, and frame select returns high for exactly one serial period between every two words. This lets the receiving device reload its shift register. The serial half period is a fixed number of system clocks set by a parameter.

Top module: `sser_master`

## Requirements
- R1: Outside a frame (frame_n_o high) the serial clock is high, the data line is low and the output enable is low. This holds from reset onwards.
- R2: A word is taken (q_pop_o high for one cycle) only while enable_i and q_valid_i are both high and no frame is active. Frame select goes low in the cycle after the pop.
- R3: Exactly HALF_DIV system cycles after frame select falls, tx_oe_o rises. Until then the data line stays low.
- R4: The first falling edge of the serial clock comes 2*HALF_DIV cycles after frame select falls. Each word produces exactly as many falling edges as its length.
- R5: The data bits appear most significant bit first. The first bit is present when the output enable rises. Each later bit changes only on a rising clock edge, so the data line is stable while the clock is low.
- R6: The incoming line is sampled on every falling edge. The received word is right-justified in rx_word_o with all bits above the word length zero: the first sampled bit lands at position length-1 and the last at position 0.
- R7: Frame select rises 2*HALF_DIV cycles after the last falling edge, so a word of n bits holds frame select low for 2*HALF_DIV*(n+1) cycles.
- R8: When a further word is queued and enabled at the end of a word, frame select stays high for exactly 2*HALF_DIV cycles with the clock high, and the next frame then starts.
- R9: rx_valid_o is high for exactly one cycle per word: the first cycle in which frame select is high after that word.
- R10: word_len_i is latched when a word is taken, and changing it during a frame has no effect on that frame. Values below 4 are used as 4 and values above 16 as 16.
- R11: If enable_i drops during a frame, the current word still completes. No further word is taken while enable_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| enable_i | input | 1 | Allows new words to start |
| word_len_i | input | 5 | Word length in bits, 4 to 16 |
| q_valid_i | input | 1 | Transmit queue holds a word |
| q_data_i | input | 16 | Word at the head of the queue |
| q_pop_o | output | 1 | One-cycle strobe: head word taken |
| ser_clk_o | output | 1 | Serial clock, idles high |
| frame_n_o | output | 1 | Active-low frame select |
| tx_dat_o | output | 1 | Serial data out |
| tx_oe_o | output | 1 | Output enable for the data-out pad |
| rx_dat_i | input | 1 | Serial data in |
| rx_word_o | output | 16 | Last received word, right-justified |
| rx_valid_o | output | 1 | One-cycle strobe: rx_word_o updated |

## Verification
The hardest moment to reach is the end of the inter-word high pulse. There, a queued word has to be taken at the exact cycle the pulse ends, without stretching or shortening it. The bench reaches it by loading each burst of three words before enabling, so the queue is never empty at a word boundary. It then measures every high gap and every low frame in system cycles for each length from 4 to 16. Two more cases only show up from the ports while a frame is running: a change of word_len_i and the drop of enable_i. The bench applies both a few cycles after frame select falls and measures the frame that is already under way.

// File: rtl/sser_pkg.sv
package sser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_A,
    ST_LEAD_B,
    ST_LOW,
    ST_HIGH,
    ST_GAP_A,
    ST_GAP_B
  } sser_state_e;
endpackage

// File: rtl/sser_half_timer.sv
module sser_half_timer #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the half-period counter never passes its terminal value
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              rx_bit_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DATA_W);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  assign tx_bit_o  = tx_q[DATA_W-1];
  assign rx_word_o = rx_q;

  always_comb begin
    tx_d = tx_q;
    if (load_i)       tx_d = word_i << (FULL - len_i);
    else if (shift_i) tx_d = {tx_q[DATA_W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (load_i)        rx_d = '0;
    else if (sample_i) rx_d = {rx_q[DATA_W-2:0], rx_bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  // R5: loading and shifting are never requested together
  a_r5_load_excl_shift: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !shift_i);
endmodule

// File: rtl/sser_master.sv
module sser_master
  import sser_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MIN_LEN  = 4,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable_i,
  input  logic [$clog2(DATA_W+1)-1:0]  word_len_i,
  input  logic                         q_valid_i,
  input  logic [DATA_W-1:0]            q_data_i,
  output logic                         q_pop_o,
  output logic                         ser_clk_o,
  output logic                         frame_n_o,
  output logic                         tx_dat_o,
  output logic                         tx_oe_o,
  input  logic                         rx_dat_i,
  output logic [DATA_W-1:0]            rx_word_o,
  output logic                         rx_valid_o
);
  localparam int unsigned LEN_W = $clog2(DATA_W + 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

  sser_state_e       state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rxw_q, rxw_d;
  logic              rxv_q, rxv_d;

  logic              tick, run;
  logic [LEN_W-1:0]  len_eff;
  logic              start, last, sample, shift, word_done;
  logic              tx_bit;
  logic [DATA_W-1:0] sh_rx_word;

  // Half-period time base
  assign run = (state_q != ST_IDLE);

  sser_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  // Length clamp to the supported range
  always_comb begin
    if (word_len_i < LEN_MIN)      len_eff = LEN_MIN;
    else if (word_len_i > LEN_MAX) len_eff = LEN_MAX;
    else                           len_eff = word_len_i;
  end

  // Control events
  assign start     = enable_i && q_valid_i &&
                     ((state_q == ST_IDLE) || ((state_q == ST_GAP_B) && tick));
  assign last      = (cnt_q == len_q);
  assign sample    = tick && ((state_q == ST_LEAD_B) || ((state_q == ST_HIGH) && !last));
  assign shift     = tick && (state_q == ST_LOW) && !last;
  assign word_done = tick && (state_q == ST_HIGH) && last;

  sser_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start),
    .word_i    (q_data_i),
    .len_i     (len_eff),
    .shift_i   (shift),
    .sample_i  (sample),
    .rx_bit_i  (rx_dat_i),
    .tx_bit_o  (tx_bit),
    .rx_word_o (sh_rx_word)
  );

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_LEAD_A;
      ST_LEAD_A: if (tick)  state_d = ST_LEAD_B;
      ST_LEAD_B: if (tick)  state_d = ST_LOW;
      ST_LOW:    if (tick)  state_d = ST_HIGH;
      ST_HIGH:   if (tick)  state_d = last ? ST_GAP_A : ST_LOW;
      ST_GAP_A:  if (tick)  state_d = ST_GAP_B;
      ST_GAP_B:  if (tick)  state_d = start ? ST_LEAD_A : ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    len_d = len_q;
    cnt_d = cnt_q;
    rxw_d = rxw_q;
    rxv_d = word_done;
    if (start) begin
      len_d = len_eff;
      cnt_d = '0;
    end else if (sample) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (word_done) rxw_d = sh_rx_word;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= LEN_MIN;
      cnt_q   <= '0;
      rxw_q   <= '0;
      rxv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
      rxw_q   <= rxw_d;
      rxv_q   <= rxv_d;
    end
  end

  // Moore outputs
  assign q_pop_o    = start;
  assign ser_clk_o  = (state_q != ST_LOW);
  assign frame_n_o  = (state_q == ST_IDLE) || (state_q == ST_GAP_A) || (state_q == ST_GAP_B);
  assign tx_oe_o    = (state_q == ST_LEAD_B) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign tx_dat_o   = tx_oe_o && tx_bit;
  assign rx_word_o  = rxw_q;
  assign rx_valid_o = rxv_q;

  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_o |-> (ser_clk_o && !tx_oe_o && !tx_dat_o));

  a_r2_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop_o |-> (enable_i && q_valid_i && frame_n_o));

  a_r2_frame_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop_o |=> !frame_n_o);

  a_r3_clock_inside_driven_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_clk_o |-> (tx_oe_o && !frame_n_o));

  a_r5_data_stable_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_clk_o && !$past(ser_clk_o)) |-> $stable(tx_dat_o));

  a_r6_upper_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> ((rx_word_o >> len_q) == '0));

  a_r9_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r9_valid_at_frame_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (frame_n_o && !$past(frame_n_o)));

  a_r10_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n_o |-> ((len_q >= LEN_MIN) && (len_q <= LEN_MAX)));
endmodule

// File: tb/sser_master_tb_top.sv
`timescale 1ns/1ps
module sser_master_tb_top;
  localparam int HALF = 2;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        enable = 1'b0;
  logic [4:0]  word_len = 5'd8;
  logic        q_valid, q_pop;
  logic [15:0] q_data;
  logic        ser_clk, frame_n, tx_dat, tx_oe;
  logic        rx_dat = 1'b0;
  logic [15:0] rx_word;
  logic        rx_valid;

  logic [15:0] q_mem [8];
  logic [15:0] s_mem [8];
  int pops = 0;
  int q_total = 0;
  int exp_len = 8;
  int burst_base = 0;

  assign q_valid = (pops < q_total);
  assign q_data  = q_mem[pops % 8];

  sser_master #(.DATA_W(DW), .MIN_LEN(4), .HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .word_len_i(word_len),
    .q_valid_i(q_valid), .q_data_i(q_data), .q_pop_o(q_pop),
    .ser_clk_o(ser_clk), .frame_n_o(frame_n), .tx_dat_o(tx_dat), .tx_oe_o(tx_oe),
    .rx_dat_i(rx_dat), .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(posedge clk) if (rst_n && q_pop) pops <= pops + 1;

  // Slave model: MSB at frame fall, next bit on each rising clock edge
  int sl_frames = 0;
  int sl_idx = 0;
  logic sl_active = 1'b0;
  logic [15:0] sl_word = '0;
  always @(negedge frame_n or posedge frame_n or posedge ser_clk) begin
    if (frame_n === 1'b1) begin
      sl_active = 1'b0;
    end else if (frame_n === 1'b0 && !sl_active) begin
      sl_active = 1'b1;
      sl_word = s_mem[sl_frames % 8];
      sl_frames++;
      sl_idx = exp_len - 1;
      rx_dat = sl_word[sl_idx];
    end else if (frame_n === 1'b0 && sl_idx > 0) begin
      sl_idx--;
      rx_dat = sl_word[sl_idx];
    end
  end

  // Monitor: cycle-accurate timing and data checks
  int mon_chk = 0, mon_bad = 0;
  int mon_frames = 0, done_frames = 0;
  int low_cnt = 0, high_cnt = 0, falls = 0, cur_len = 8;
  logic [15:0] cap = '0, cur_tx = '0, cur_sl = '0, mask;
  logic prev_frame = 1'b1, prev_sclk = 1'b1, prev_oe = 1'b0, pop_prev = 1'b0;

  task automatic mchk(input bit ok, input string req, input string what, input int act, input int exp);
    mon_chk++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mask = 16'((32'd1 << cur_len) - 1);
      if (prev_frame && !frame_n) begin
        if (mon_frames > burst_base)
          mchk(high_cnt == 2*HALF, "R8", "gap length", high_cnt, 2*HALF);
        cur_len = exp_len;
        mask = 16'((32'd1 << cur_len) - 1);
        cur_tx = q_mem[mon_frames % 8];
        cur_sl = s_mem[mon_frames % 8];
        mon_frames++;
        low_cnt = 1; falls = 0; cap = '0;
        mchk(!tx_oe && !tx_dat, "R3", "driver off at frame start", {tx_oe, tx_dat}, 0);
      end else if (!frame_n) begin
        low_cnt++;
      end
      if (!frame_n && tx_oe && !prev_oe) begin
        mchk(low_cnt == HALF + 1, "R3", "enable offset", low_cnt, HALF + 1);
        mchk(tx_dat == cur_tx[cur_len-1], "R5", "first bit", tx_dat, cur_tx[cur_len-1]);
      end
      if (!frame_n && prev_sclk && !ser_clk) begin
        falls++;
        if (falls == 1) mchk(low_cnt == 2*HALF + 1, "R4", "first falling edge", low_cnt, 2*HALF + 1);
        cap = {cap[14:0], tx_dat};
      end
      if (!prev_frame && frame_n) begin
        mchk(low_cnt == 2*HALF*(cur_len + 1), "R7", "frame low length", low_cnt, 2*HALF*(cur_len + 1));
        mchk(falls == cur_len, "R4", "falling edges", falls, cur_len);
        mchk(cap == (cur_tx & mask), "R5", "serial data", cap, cur_tx & mask);
        mchk(rx_valid == 1'b1, "R9", "valid at frame rise", rx_valid, 1);
        mchk(rx_word == (cur_sl & mask), "R6", "received word", rx_word, cur_sl & mask);
        high_cnt = 1;
        done_frames++;
      end else begin
        if (frame_n) high_cnt++;
        if (rx_valid) mchk(1'b0, "R9", "stray valid", 1, 0);
      end
      if (pop_prev) mchk(!frame_n, "R2", "frame low after pop", frame_n, 0);
      pop_prev  = q_pop;
      prev_frame = frame_n;
      prev_sclk  = ser_clk;
      prev_oe    = tx_oe;
    end
  end

  // Main sequence
  int n_chk = 0, n_bad = 0;
  bit wd_hit = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk({frame_n, ser_clk, tx_oe, tx_dat} == 4'b1100, req, "idle levels",
        {frame_n, ser_clk, tx_oe, tx_dat}, 4'b1100);
  endtask

  task automatic wait_frames(input int target);
    for (int i = 0; i < 20000 && done_frames < target; i++) @(negedge clk);
    chk(done_frames >= target, "R7", "frames completed", done_frames, target);
  endtask

  task automatic fill(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      q_mem[(q_total + k) % 8] = 16'((seed * 40503 + k * 12345 + 16'h3C5A) & 16'hFFFF);
      s_mem[(q_total + k) % 8] = 16'((seed * 29 + k * 51001 + 16'h9E37) & 16'hFFFF);
    end
  endtask

  task automatic burst(input int len_in, input int eff, input int n, input int seed, input string req);
    int target;
    @(negedge clk);
    word_len = 5'(len_in);
    exp_len = eff;
    burst_base = mon_frames;
    fill(n, seed);
    target = done_frames + n;
    q_total = q_total + n;
    enable = 1'b1;
    wait_frames(target);
    repeat (2*HALF + 2) @(negedge clk);
    check_idle("R1");
    chk(pops == q_total, req, "all words taken", pops, q_total);
  endtask

  task automatic run_all();
    int target;
    int bad;
    // Reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");
    chk({q_pop, rx_valid} == 2'b00, "R1", "strobes low after reset", {q_pop, rx_valid}, 0);

    // R2: no start while disabled
    exp_len = 8; word_len = 5'd8; burst_base = mon_frames;
    fill(1, 7);
    q_total = q_total + 1;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!frame_n || q_pop) bad++;
    end
    chk(bad == 0, "R2", "disabled cycles with activity", bad, 0);
    chk(pops == 0, "R2", "no pop while disabled", pops, 0);
    target = done_frames + 1;
    enable = 1'b1;
    wait_frames(target);

    // Sweep all lengths: single and back-to-back bursts
    for (int len = 4; len <= 16; len++) begin
      burst(len, len, 1, len, "R2");
      burst(len, len, 3, len * 3 + 1, "R8");
    end
    // Extreme data patterns
    @(negedge clk);
    q_mem[q_total % 8] = 16'hFFFF; s_mem[q_total % 8] = 16'h0000;
    word_len = 5'd16; exp_len = 16; burst_base = mon_frames;
    target = done_frames + 1; q_total++;
    wait_frames(target);
    @(negedge clk);
    q_mem[q_total % 8] = 16'h0000; s_mem[q_total % 8] = 16'hFFFF;
    word_len = 5'd4; exp_len = 4; burst_base = mon_frames;
    target = done_frames + 1; q_total++;
    wait_frames(target);

    // R10: clamp below and above range
    burst(2, 4, 2, 91, "R10");
    burst(0, 4, 1, 92, "R10");
    burst(20, 16, 2, 93, "R10");
    burst(31, 16, 1, 94, "R10");

    // R10: length change inside a frame is ignored
    @(negedge clk);
    word_len = 5'd8; exp_len = 8; burst_base = mon_frames;
    fill(1, 95);
    target = done_frames + 1; q_total++;
    for (int i = 0; i < 100 && frame_n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    word_len = 5'd13;
    wait_frames(target);
    chk(done_frames == target, "R10", "latched length frame done", done_frames, target);

    // R11: enable dropped mid-frame
    @(negedge clk);
    word_len = 5'd6; exp_len = 6; burst_base = mon_frames;
    fill(2, 96);
    target = done_frames + 1; q_total = q_total + 2;
    for (int i = 0; i < 100 && frame_n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    wait_frames(target);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!frame_n || q_pop) bad++;
    end
    chk(bad == 0, "R11", "no new frame while disabled", bad, 0);
    chk(pops == q_total - 1, "R11", "one word left queued", pops, q_total - 1);
    burst_base = mon_frames;
    target = done_frames + 1;
    enable = 1'b1;
    wait_frames(target);
    repeat (2*HALF + 2) @(negedge clk);
    check_idle("R1");
    chk(pops == q_total, "R11", "remaining word sent", pops, q_total);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk, n_bad + mon_bad);
    $finish;
  end
endmodule